// File: doc/BRIEF.md
# Paged Program Counter Unit

This block keeps the 13-bit program counter of a small accumulator-style microcontroller core and decides the next fetch address every cycle. The decoder in front of it sends one already-decoded command per cycle (advance, skip, jump, call, return, low-byte write), along with the instruction's address field, a data byte and a strobe that writes the upper-bits holding latch. The unit puts together branch targets from the address field and page bits. It keeps return addresses in a small circular hardware stack. It also marks the cycle after any flow change as a bubble, because the prefetched instruction in that cycle is thrown away.

The `legacy_mode` input selects an older variant with a narrower instruction word. In that variant the page comes from two status-register bits, the address space is 2K words, and calls and computed jumps can only reach the lower half of a 512-word page. In the default wide mode, the page bits come from the holding latch, which software loads before a jump or a low-byte write.

Top module: `page_pc_unit`

## Requirements
- R1: While `rst` is high at a clock edge, the next state has `fetch_pc`=0, `pc_latch`=0, `bubble`=0 and the stack pointer at entry 0.
- R2: `cmd`=0 (advance, and also the unused codes 6 and 7) sets the PC to PC+1. `cmd`=5 (skip) sets it to PC+2 and causes a bubble. In wide mode the sum wraps modulo 2^13. In legacy mode it wraps modulo 2^11 and bits 12:11 stay 0.
- R3: In wide mode, `cmd`=1 (jump) and `cmd`=2 (call) load PC[10:0] from `op_addr` and PC[12:11] from `pc_latch[4:3]`.
- R4: `cmd`=2 pushes PC+1, wrapped as in R2. `cmd`=3 (any return flavour) loads the PC from the top of the stack and pops it. A return leaves `pc_latch` unchanged.
- R5: In wide mode, `cmd`=4 (low-byte write) loads the whole PC as {`pc_latch`, `wr_data`}, using the latch value from before any write in the same cycle.
- R6: `pcl_rd` always equals `fetch_pc[7:0]`. Reading it never changes `pc_latch`.
- R7: In legacy mode, a jump loads the PC with {2'b00, `status_page`, `op_addr[8:0]`}.
- R8: In legacy mode, a call loads {2'b00, `status_page`, 1'b0, `op_addr[7:0]`} and a low-byte write loads {2'b00, `status_page`, 1'b0, `wr_data`}, so bit 8 is 0.
- R9: Every command other than advance raises `bubble` for exactly the next cycle. In that cycle the PC holds, and `cmd` and `latch_wr` have no effect.
- R10: The stack has 8 entries and is circular. A ninth push overwrites the oldest entry. A pop from empty wraps to entry 7. No error is raised in either case.
- R11: `latch_wr` outside a bubble loads `pc_latch` with `wr_data[4:0]` at the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| legacy_mode | input | 1 | 1 selects the narrow-instruction variant |
| cmd | input | 3 | Decoded command code |
| op_addr | input | 11 | Address field of the instruction |
| wr_data | input | 8 | Byte for a low-byte write or a latch write |
| latch_wr | input | 1 | Write strobe for the holding latch |
| status_page | input | 2 | Page bits from the status register (legacy mode) |
| fetch_pc | output | 13 | Current program counter / fetch address |
| pcl_rd | output | 8 | Low PC byte as read by software |
| pc_latch | output | 5 | Holding latch for the upper PC bits |
| bubble | output | 1 | The current cycle is the discarded slot after a flow change |

## Verification
The assertions assume that `cmd` holds one code per cycle and that `legacy_mode` does not change in the cycle where a legacy-target check looks at its result. The stimulus changes all inputs only on the falling edge, so every command is stable across the edge that takes it. Random runs draw the mode, codes, fields and strobes freely, bubble cycles included, so the bench shows that ignored inputs really are ignored. Directed runs cover nine-deep call chains, unbalanced returns and the wrap points of both address spaces.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
    typedef enum logic [2:0] {
        CMD_ADV   = 3'd0,
        CMD_JMP   = 3'd1,
        CMD_CALL  = 3'd2,
        CMD_RET   = 3'd3,
        CMD_PCLWR = 3'd4,
        CMD_SKIP  = 3'd5
    } pcu_cmd_e;

    localparam int LEG_PC_W   = 11;
    localparam int LEG_PAGE_W = 2;
endpackage

// File: rtl/pcu_target.sv
module pcu_target #(
    parameter int PC_W    = 13,
    parameter int ADDR_W  = 11,
    parameter int LATCH_W = 5
) (
    input  logic                              legacy,
    input  logic [PC_W-1:0]                   pc,
    input  logic [ADDR_W-1:0]                 addr,
    input  logic [7:0]                        data,
    input  logic [LATCH_W-1:0]                latch,
    input  logic [pcu_pkg::LEG_PAGE_W-1:0]    page,
    output logic [PC_W-1:0]                   inc1,
    output logic [PC_W-1:0]                   inc2,
    output logic [PC_W-1:0]                   tgt_jmp,
    output logic [PC_W-1:0]                   tgt_call,
    output logic [PC_W-1:0]                   tgt_pcl
);
    import pcu_pkg::*;

    localparam int HI_W     = PC_W - ADDR_W;
    localparam int LEG_JW   = LEG_PC_W - LEG_PAGE_W;
    localparam int LEG_CW   = LEG_JW - 1;

    logic [PC_W-1:0]     wide_jmp, wide_pcl;
    logic [PC_W-1:0]     leg_jmp, leg_call, leg_pcl;
    logic [LEG_PC_W-1:0] leg_inc1, leg_inc2;

    always_comb begin
        wide_jmp = {latch[LATCH_W-1 -: HI_W], addr};
        wide_pcl = PC_W'({latch, data});
        leg_jmp  = PC_W'({page, addr[LEG_JW-1:0]});
        leg_call = PC_W'({page, 1'b0, addr[LEG_CW-1:0]});
        leg_pcl  = PC_W'({page, 1'b0, data});
        leg_inc1 = pc[LEG_PC_W-1:0] + LEG_PC_W'(1);
        leg_inc2 = pc[LEG_PC_W-1:0] + LEG_PC_W'(2);
        if (legacy) begin
            inc1     = PC_W'(leg_inc1);
            inc2     = PC_W'(leg_inc2);
            tgt_jmp  = leg_jmp;
            tgt_call = leg_call;
            tgt_pcl  = leg_pcl;
        end else begin
            inc1     = pc + PC_W'(1);
            inc2     = pc + PC_W'(2);
            tgt_jmp  = wide_jmp;
            tgt_call = wide_jmp;
            tgt_pcl  = wide_pcl;
        end
    end
endmodule

// File: rtl/pcu_ret_stack.sv
module pcu_ret_stack #(
    parameter int DEPTH = 8,
    parameter int W     = 13
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] push_data,
    output logic [W-1:0] top_data
);
    localparam int SP_W = $clog2(DEPTH);

    logic [SP_W-1:0] sp_d, sp_q;
    logic [W-1:0]    ent_q [DEPTH];
    logic [SP_W-1:0] top_idx;

    always_comb begin
        sp_d = sp_q;
        if (push)      sp_d = sp_q + SP_W'(1);
        else if (pop)  sp_d = sp_q - SP_W'(1);
        top_idx  = sp_q - SP_W'(1);
        top_data = ent_q[top_idx];
    end

    always_ff @(posedge clk) begin
        if (rst) sp_q <= '0;
        else     sp_q <= sp_d;
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst)                             ent_q[i] <= '0;
            else if (push && sp_q == SP_W'(i))   ent_q[i] <= push_data;
        end
    end

    assert_push_advances_R10: assert property (@(posedge clk) disable iff (rst)
        push |=> sp_q == $past(sp_q) + SP_W'(1));
    assert_pop_retreats_R10: assert property (@(posedge clk) disable iff (rst)
        pop |=> sp_q == $past(sp_q) - SP_W'(1));
    assert_no_push_pop_R4: assert property (@(posedge clk) disable iff (rst)
        !(push && pop));
endmodule

// File: rtl/page_pc_unit.sv
module page_pc_unit #(
    parameter int PC_W        = 13,
    parameter int ADDR_W      = 11,
    parameter int LATCH_W     = 5,
    parameter int STACK_DEPTH = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                legacy_mode,
    input  logic [2:0]          cmd,
    input  logic [ADDR_W-1:0]   op_addr,
    input  logic [7:0]          wr_data,
    input  logic                latch_wr,
    input  logic [1:0]          status_page,
    output logic [PC_W-1:0]     fetch_pc,
    output logic [7:0]          pcl_rd,
    output logic [LATCH_W-1:0]  pc_latch,
    output logic                bubble
);
    import pcu_pkg::*;

    typedef struct packed {
        logic [PC_W-1:0]    pc;
        logic [LATCH_W-1:0] latch;
        logic               bub;
    } pcu_state_t;

    pcu_state_t st_d, st_q;
    pcu_cmd_e   cmd_e;
    logic       push, pop;
    logic [PC_W-1:0] inc1, inc2, tgt_jmp, tgt_call, tgt_pcl, top_data;

    pcu_target #(.PC_W(PC_W), .ADDR_W(ADDR_W), .LATCH_W(LATCH_W)) u_target (
        .legacy   (legacy_mode),
        .pc       (st_q.pc),
        .addr     (op_addr),
        .data     (wr_data),
        .latch    (st_q.latch),
        .page     (status_page),
        .inc1     (inc1),
        .inc2     (inc2),
        .tgt_jmp  (tgt_jmp),
        .tgt_call (tgt_call),
        .tgt_pcl  (tgt_pcl)
    );

    pcu_ret_stack #(.DEPTH(STACK_DEPTH), .W(PC_W)) u_stack (
        .clk       (clk),
        .rst       (rst),
        .push      (push),
        .pop       (pop),
        .push_data (inc1),
        .top_data  (top_data)
    );

    always_comb begin
        cmd_e = pcu_cmd_e'(cmd);
        st_d  = st_q;
        push  = 1'b0;
        pop   = 1'b0;
        if (st_q.bub) begin
            st_d.bub = 1'b0;
        end else begin
            if (latch_wr) st_d.latch = wr_data[LATCH_W-1:0];
            st_d.bub = 1'b1;
            case (cmd_e)
                CMD_JMP:   st_d.pc = tgt_jmp;
                CMD_CALL:  begin st_d.pc = tgt_call; push = 1'b1; end
                CMD_RET:   begin st_d.pc = top_data; pop = 1'b1; end
                CMD_PCLWR: st_d.pc = tgt_pcl;
                CMD_SKIP:  st_d.pc = inc2;
                default:   begin st_d.pc = inc1; st_d.bub = 1'b0; end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign fetch_pc = st_q.pc;
    assign pcl_rd   = st_q.pc[7:0];
    assign pc_latch = st_q.latch;
    assign bubble   = st_q.bub;

    assert_flow_bubble_R9: assert property (@(posedge clk) disable iff (rst)
        (!bubble && cmd inside {3'd1, 3'd2, 3'd3, 3'd4, 3'd5}) |=> bubble);
    assert_single_bubble_R9: assert property (@(posedge clk) disable iff (rst)
        bubble |=> !bubble);
    assert_bubble_holds_pc_R9: assert property (@(posedge clk) disable iff (rst)
        bubble |=> fetch_pc == $past(fetch_pc));
    assert_ret_keeps_latch_R4: assert property (@(posedge clk) disable iff (rst)
        (!bubble && cmd == 3'd3 && !latch_wr) |=> $stable(pc_latch));
    assert_wide_step_R2: assert property (@(posedge clk) disable iff (rst)
        (!bubble && !legacy_mode && cmd == 3'd0) |=> fetch_pc == $past(fetch_pc) + PC_W'(1));
    assert_legacy_low_half_R8: assert property (@(posedge clk) disable iff (rst)
        (!bubble && legacy_mode && cmd inside {3'd2, 3'd4})
        |=> (fetch_pc[8] == 1'b0 && fetch_pc[PC_W-1:LEG_PC_W] == '0));
    assert_pcl_mirror_R6: assert property (@(posedge clk) disable iff (rst)
        pcl_rd == fetch_pc[7:0]);
endmodule

// File: tb/page_pc_unit_bench.sv
module page_pc_unit_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        legacy_mode = 1'b0;
    logic [2:0]  cmd = 3'd0;
    logic [10:0] op_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        latch_wr = 1'b0;
    logic [1:0]  status_page = '0;
    logic [12:0] fetch_pc;
    logic [7:0]  pcl_rd;
    logic [4:0]  pc_latch;
    logic        bubble;

    int n_tests = 0;
    int n_fail  = 0;

    logic [12:0] m_pc;
    logic [4:0]  m_latch;
    logic        m_bub;
    logic [12:0] m_stk [8];
    logic [2:0]  m_sp;

    always #2 clk = ~clk;

    page_pc_unit u_page_pc_unit (
        .clk(clk), .rst(rst), .legacy_mode(legacy_mode), .cmd(cmd),
        .op_addr(op_addr), .wr_data(wr_data), .latch_wr(latch_wr),
        .status_page(status_page), .fetch_pc(fetch_pc), .pcl_rd(pcl_rd),
        .pc_latch(pc_latch), .bubble(bubble)
    );

    function automatic logic [12:0] step_pc(input logic [12:0] pc, input logic leg, input int n);
        logic [10:0] s;
        if (leg) begin
            s = pc[10:0] + 11'(n);
            return {2'b00, s};
        end
        return pc + 13'(n);
    endfunction

    function automatic string tag_of(input logic [2:0] c, input logic leg, input logic bub);
        if (bub) return "R9";
        case (c)
            3'd1: return leg ? "R7" : "R3";
            3'd2: return leg ? "R8" : "R3";
            3'd3: return "R4";
            3'd4: return leg ? "R8" : "R5";
            default: return "R2";
        endcase
    endfunction

    task automatic check(input string req);
        n_tests++;
        if (fetch_pc !== m_pc || pcl_rd !== m_pc[7:0] || pc_latch !== m_latch || bubble !== m_bub) begin
            n_fail++;
            $display("FAIL %s: pc=%h pcl=%h latch=%h bub=%b expected pc=%h pcl=%h latch=%h bub=%b",
                     req, fetch_pc, pcl_rd, pc_latch, bubble, m_pc, m_pc[7:0], m_latch, m_bub);
        end
    endtask

    task automatic cyc(input logic [2:0] c, input logic [10:0] a, input logic [7:0] d,
                       input logic lw, input logic leg, input logic [1:0] pg, input string req);
        logic [12:0] nx;
        string t;
        cmd = c; op_addr = a; wr_data = d; latch_wr = lw; legacy_mode = leg; status_page = pg;
        t = (req == "") ? tag_of(c, leg, m_bub) : req;
        if (m_bub) begin
            m_bub = 1'b0;
        end else begin
            nx = step_pc(m_pc, leg, 1);
            m_bub = 1'b1;
            case (c)
                3'd1: nx = leg ? {2'b00, pg, a[8:0]} : {m_latch[4:3], a};
                3'd2: begin
                    m_stk[m_sp] = step_pc(m_pc, leg, 1);
                    m_sp = m_sp + 3'd1;
                    nx = leg ? {2'b00, pg, 1'b0, a[7:0]} : {m_latch[4:3], a};
                end
                3'd3: begin m_sp = m_sp - 3'd1; nx = m_stk[m_sp]; end
                3'd4: nx = leg ? {2'b00, pg, 1'b0, d} : {m_latch, d};
                3'd5: nx = step_pc(m_pc, leg, 2);
                default: m_bub = 1'b0;
            endcase
            if (lw) m_latch = d[4:0];
            m_pc = nx;
        end
        @(posedge clk);
        @(negedge clk);
        check(t);
    endtask

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        m_pc = '0; m_latch = '0; m_bub = 1'b0; m_sp = '0;
        for (int i = 0; i < 8; i++) m_stk[i] = '0;
        // dirty some state, then reset: R1
        @(negedge clk); rst = 1'b0;
        cmd = 3'd1; op_addr = 11'h5A5; wr_data = 8'hFF; latch_wr = 1'b1;
        @(negedge clk); @(negedge clk);
        rst = 1'b1; cmd = 3'd0; latch_wr = 1'b0;
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        check("R1");
        // R11 latch load, then wide jump R3
        cyc(3'd0, 11'h0, 8'h18, 1'b1, 1'b0, 2'd0, "R11");
        cyc(3'd1, 11'h123, 8'h00, 1'b0, 1'b0, 2'd0, "R3");
        // bubble: call + latch write ignored (R9)
        cyc(3'd2, 11'h7FF, 8'h07, 1'b1, 1'b0, 2'd0, "R9");
        // R5 low-byte write with latch written in same cycle (old latch used)
        cyc(3'd0, 11'h0, 8'h15, 1'b1, 1'b0, 2'd0, "R11");
        cyc(3'd4, 11'h0, 8'h7A, 1'b1, 1'b0, 2'd0, "R5");
        cyc(3'd0, 11'h0, 8'h00, 1'b0, 1'b0, 2'd0, "R9");
        // R6: several advances, pcl_rd mirrors, latch untouched
        for (int i = 0; i < 4; i++) cyc(3'd0, 11'h0, 8'h00, 1'b0, 1'b0, 2'd0, "R6");
        // R4: call then return; return keeps latch
        cyc(3'd2, 11'h040, 8'h00, 1'b0, 1'b0, 2'd0, "R4");
        cyc(3'd0, 11'h0, 8'h00, 1'b0, 1'b0, 2'd0, "R9");
        cyc(3'd3, 11'h0, 8'h00, 1'b0, 1'b0, 2'd0, "R4");
        cyc(3'd0, 11'h0, 8'h00, 1'b0, 1'b0, 2'd0, "R9");
        // R10: nine nested calls, then nine returns
        for (int i = 0; i < 9; i++) begin
            cyc(3'd2, 11'(i * 16), 8'h00, 1'b0, 1'b0, 2'd0, "R10");
            cyc(3'd0, 11'h0, 8'h00, 1'b0, 1'b0, 2'd0, "R10");
        end
        for (int i = 0; i < 9; i++) begin
            cyc(3'd3, 11'h0, 8'h00, 1'b0, 1'b0, 2'd0, "R10");
            cyc(3'd0, 11'h0, 8'h00, 1'b0, 1'b0, 2'd0, "R10");
        end
        // R2 wide wrap at top and skip
        cyc(3'd0, 11'h0, 8'h1F, 1'b1, 1'b0, 2'd0, "R11");
        cyc(3'd1, 11'h7FF, 8'h00, 1'b0, 1'b0, 2'd0, "R3");
        cyc(3'd0, 11'h0, 8'h00, 1'b0, 1'b0, 2'd0, "R9");
        cyc(3'd0, 11'h0, 8'h00, 1'b0, 1'b0, 2'd0, "R2");
        cyc(3'd5, 11'h0, 8'h00, 1'b0, 1'b0, 2'd0, "R2");
        cyc(3'd0, 11'h0, 8'h00, 1'b0, 1'b0, 2'd0, "R9");
        // legacy: R7 jump, R8 call and low-byte write, R2 wrap at 2K
        cyc(3'd1, 11'h7FF, 8'h00, 1'b0, 1'b1, 2'd2, "R7");
        cyc(3'd0, 11'h0, 8'h00, 1'b0, 1'b1, 2'd2, "R9");
        cyc(3'd2, 11'h3FF, 8'h00, 1'b0, 1'b1, 2'd3, "R8");
        cyc(3'd0, 11'h0, 8'h00, 1'b0, 1'b1, 2'd3, "R9");
        cyc(3'd4, 11'h0, 8'hAB, 1'b0, 1'b1, 2'd1, "R8");
        cyc(3'd0, 11'h0, 8'h00, 1'b0, 1'b1, 2'd1, "R9");
        cyc(3'd1, 11'h1FF, 8'h00, 1'b0, 1'b1, 2'd3, "R7");
        cyc(3'd0, 11'h0, 8'h00, 1'b0, 1'b1, 2'd3, "R9");
        cyc(3'd0, 11'h0, 8'h00, 1'b0, 1'b1, 2'd3, "R2");
        // constrained random mix
        for (int i = 0; i < 4000; i++) begin
            logic [2:0] c;
            c = 3'($urandom_range(0, 7));
            cyc(c, 11'($urandom), 8'($urandom), 1'($urandom_range(0, 3) == 0),
                1'($urandom_range(0, 3) == 0), 2'($urandom), "");
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule